// File: doc/BRIEF.md
# MDIO PHY Management Slave

This block is the PHY end of a clause-22 serial management link. It watches the management clock and data pins, recognises management frames, and serves a 32-entry, 16-bit register file that describes a simple 10/100 PHY. Write frames update plain storage. Read frames make the block drive the data pin through an output-enable for the turnaround and data phases.

Three of the registers are not stored. Their read value is formed from the live advertisement register and the link-status input, so the PHY always appears to have negotiated exactly what the host advertised. Both the management clock and the data input are brought into the system clock domain. Frame decoding runs on the detected rising edges of the management clock. Read data is launched on the detected falling edges.

Top module: `mdio_phy_slave`

## Requirements
- R1: A frame starts only after at least 32 consecutive ones sampled on management-clock rising edges, followed by a sampled zero. A zero after fewer than 32 ones is ignored, and the frame that follows has no effect.
- R2: After the two start bits come a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits, each field MSB first. Opcode 2'b10 is a read, and the 16 register bits are returned MSB first.
- R3: On a read to the block's own address, the block drives 0 during the second turnaround bit.
- R4: Opcode 2'b01 to the block's own address writes the 16 data bits into the register selected by the 5-bit register address. The write takes effect after the 16th data bit. Registers other than 1, 5 and 18 read back what was last written.
- R5: A frame whose PHY address differs from the `phy_addr` input never drives the pin, so it reads all ones from the pulled-up line. A write to another address changes nothing.
- R6: After reset the registers read: register 0 = 0x3100, 2 = 0x0300, 3 = 0xE400, 4 = 0x01E1, all other stored registers 0. The output-enable is low.
- R7: Register 1 reads 0x782C while `link_up` is 1 and 0x0000 while it is 0. Writes to it do not change what it reads.
- R8: Register 5 reads 0x4001 OR (register 4 AND 0x01E0).
- R9: Register 18 reads 0 while the link is down. While the link is up, its bit 11 is register 4 bit 8 OR bit 6, its bit 10 is register 4 bit 7 OR bit 8, and all other bits are 0.
- R10: The output-enable is high only during the turnaround and data phases of a matching read, and it is released after the 16th data bit. Read data changes only after a falling edge of the management clock.
- R11: Opcodes 2'b00 and 2'b11 neither write nor drive the pin.
- R12: If the second start bit is 0, the frame is abandoned: it writes nothing, and the block returns to looking for a preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | PHY address this block answers to |
| link_up | input | 1 | Link status, 1 = link up |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data as seen on the line |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Output-enable for `mdio_o` |

## Verification
Directed frames cover the edge cases:
- A preamble one bit short, which separates counting from mere start-bit detection.
- A broken start field.
- The two unused opcodes.
- A foreign PHY address, which separates the address compare from opcode decode.
- Register 4 values that set a single advertisement bit each, which separate the two OR terms of register 18 and the copied field of register 5.
- A link toggle, which separates the live link view from stored data.

Seeded random frames then mix reads and writes across all register indices, both link states and a few PHY addresses. This exposes ordering errors in the shift paths and stale read data.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;

   typedef enum logic [2:0] {
      S_PRE, S_ST, S_OP, S_PA, S_RA, S_TA, S_DAT
   } mdio_state_t;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   // register indices whose behaviour is fixed by the PHY model
   localparam int REG_CTRL   = 0;
   localparam int REG_STATUS = 1;
   localparam int REG_ID_HI  = 2;
   localparam int REG_ID_LO  = 3;
   localparam int REG_ADV    = 4;
   localparam int REG_LPA    = 5;
   localparam int REG_DIAG   = 18;

   localparam logic [15:0] STATUS_UP = 16'h782C;
   localparam logic [15:0] LPA_FIXED = 16'h4001;
   localparam logic [15:0] LPA_MASK  = 16'h01E0;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc_raw,
   input  logic mdio_raw,
   output logic mdc_rise,
   output logic mdc_fall,
   output logic mdio_s
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mdio_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] mdc_pipe;
   logic [STAGES-1:0] dat_pipe;
   logic              mdc_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_pipe <= '0;
         dat_pipe <= '0;
         mdc_prev <= 1'b0;
      end else begin
         mdc_pipe <= {mdc_pipe[STAGES-2:0], mdc_raw};
         dat_pipe <= {dat_pipe[STAGES-2:0], mdio_raw};
         mdc_prev <= mdc_pipe[STAGES-1];
      end
   end

   assign mdc_rise = mdc_pipe[STAGES-1] & ~mdc_prev;
   assign mdc_fall = ~mdc_pipe[STAGES-1] & mdc_prev;
   assign mdio_s   = dat_pipe[STAGES-1];

   a_r10_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mdc_rise && mdc_fall));

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs import mdio_phy_pkg::*; #(
   parameter int AW    = 5,
   parameter int DW    = 16,
   parameter int NREGS = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_up,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   generate
      if (NREGS != (1 << AW)) begin : g_bad_depth
         $error("mdio_phy_regs: NREGS must equal 2**AW");
      end
      if (NREGS <= REG_DIAG || DW != 16) begin : g_bad_shape
         $error("mdio_phy_regs: needs 16-bit registers and index 18");
      end
   endgenerate

   function automatic logic [DW-1:0] reset_value(input int idx);
      case (idx)
         REG_CTRL:  reset_value = DW'(16'h3100);
         REG_ID_HI: reset_value = DW'(16'h0300);
         REG_ID_LO: reset_value = DW'(16'hE400);
         REG_ADV:   reset_value = DW'(16'h01E1);
         default:   reset_value = '0;
      endcase
   endfunction

   logic [DW-1:0] mem [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      localparam logic [DW-1:0] RV = reset_value(i);
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RV;
         end else if (wr_en && wr_addr == AW'(i)) begin
            q <= wr_data;
         end
      end
      assign mem[i] = q;
   end

   logic [DW-1:0] adv;
   assign adv = mem[REG_ADV];

   always_comb begin
      rd_data = mem[rd_addr];
      if (rd_addr == AW'(REG_STATUS)) begin
         rd_data = link_up ? STATUS_UP : '0;
      end else if (rd_addr == AW'(REG_LPA)) begin
         rd_data = LPA_FIXED | (adv & LPA_MASK);
      end else if (rd_addr == AW'(REG_DIAG)) begin
         rd_data = '0;
         if (link_up) begin
            rd_data[11] = adv[8] | adv[6];
            rd_data[10] = adv[7] | adv[8];
         end
      end
   end

   a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(7)) |=> mem[7] == $past(wr_data));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm import mdio_phy_pkg::*; #(
   parameter int PRE_MIN = 32,
   parameter int AW      = 5,
   parameter int DW      = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,
   input  logic          fall,
   input  logic          mdio_s,
   input  logic [AW-1:0] phy_addr,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          mdio_o,
   output logic          mdio_oe
);

   localparam int OW = $clog2(PRE_MIN + 1);
   localparam int CW = $clog2(DW);
   localparam logic [OW-1:0] PRE_LIM = OW'(PRE_MIN);
   localparam logic [CW-1:0] LAST_D  = CW'(DW - 1);
   localparam logic [CW-1:0] LAST_A  = CW'(AW - 1);

   generate
      if (PRE_MIN < 1 || AW < 2 || AW > DW) begin : g_bad_cfg
         $error("mdio_frame_fsm: illegal PRE_MIN/AW/DW combination");
      end
   endgenerate

   mdio_state_t   state;
   logic [OW-1:0] ones;
   logic [CW-1:0] cnt;
   logic [1:0]    op;
   logic [AW-1:0] pa;
   logic [AW-1:0] ra;
   logic [DW-1:0] sh;
   logic          rd_sel;

   assign rd_addr = ra;
   assign wr_addr = ra;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_PRE;
         ones    <= '0;
         cnt     <= '0;
         op      <= '0;
         pa      <= '0;
         ra      <= '0;
         sh      <= '0;
         rd_sel  <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (rise) begin
            case (state)
               S_PRE: begin
                  if (mdio_s) begin
                     if (ones != PRE_LIM) ones <= ones + 1'b1;
                  end else begin
                     if (ones == PRE_LIM) state <= S_ST;
                     ones <= '0;
                  end
               end
               S_ST: begin
                  cnt   <= '0;
                  state <= mdio_s ? S_OP : S_PRE;
               end
               S_OP: begin
                  op <= {op[0], mdio_s};
                  if (cnt == CW'(1)) begin
                     cnt   <= '0;
                     state <= S_PA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_PA: begin
                  pa <= {pa[AW-2:0], mdio_s};
                  if (cnt == LAST_A) begin
                     cnt   <= '0;
                     state <= S_RA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_RA: begin
                  ra <= {ra[AW-2:0], mdio_s};
                  if (cnt == LAST_A) begin
                     cnt    <= '0;
                     state  <= S_TA;
                     rd_sel <= (op == OP_RD) && (pa == phy_addr);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_TA: begin
                  if (cnt == '0) begin
                     sh  <= rd_data;
                     cnt <= CW'(1);
                  end else begin
                     cnt   <= '0;
                     state <= S_DAT;
                  end
               end
               S_DAT: begin
                  if (!rd_sel) sh <= {sh[DW-2:0], mdio_s};
                  if (cnt == LAST_D) begin
                     cnt     <= '0;
                     ones    <= '0;
                     state   <= S_PRE;
                     rd_sel  <= 1'b0;
                     mdio_oe <= 1'b0;
                     if (op == OP_WR && pa == phy_addr) begin
                        wr_en   <= 1'b1;
                        wr_data <= {sh[DW-2:0], mdio_s};
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= S_PRE;
            endcase
         end else if (fall && rd_sel) begin
            if (state == S_TA && cnt == CW'(1)) begin
               mdio_oe <= 1'b1;
               mdio_o  <= 1'b0;
            end else if (state == S_DAT) begin
               mdio_o <= sh[DW-1];
               sh     <= {sh[DW-2:0], 1'b0};
            end
         end
      end
   end

   a_r10_oe_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> rd_sel);

   a_r10_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $past(fall));

   a_r1_short_preamble: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PRE && rise && !mdio_s && ones != PRE_LIM) |=> state == S_PRE);

   a_r12_bad_start: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_ST && rise && !mdio_s) |=> state == S_PRE);

   a_r4_single_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave #(
   parameter int PRE_MIN     = 32,
   parameter int AW          = 5,
   parameter int DW          = 16,
   parameter int NREGS       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] phy_addr,
   input  logic          link_up,
   input  logic          mdc,
   input  logic          mdio_i,
   output logic          mdio_o,
   output logic          mdio_oe
);

   logic          rise, fall, mdio_s;
   logic          wr_en;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [DW-1:0] wr_data, rd_data;

   mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc_raw  (mdc),
      .mdio_raw (mdio_i),
      .mdc_rise (rise),
      .mdc_fall (fall),
      .mdio_s   (mdio_s)
   );

   mdio_frame_fsm #(.PRE_MIN(PRE_MIN), .AW(AW), .DW(DW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rise),
      .fall     (fall),
      .mdio_s   (mdio_s),
      .phy_addr (phy_addr),
      .rd_data  (rd_data),
      .rd_addr  (rd_addr),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

   mdio_phy_regs #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_up (link_up),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

endmodule

// File: tb/mdio_phy_slave_tb.sv
module mdio_phy_slave_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] paddr = 5'd1;
   logic       link = 1'b1;
   logic       mdc = 1'b0;
   logic       mst = 1'b1;
   logic       dut_o, dut_oe;
   logic       bus;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic oe_seen = 1'b0;
   logic [15:0] ref_regs [32];

   assign bus = dut_oe ? dut_o : mst;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (dut_oe) oe_seen = 1'b1;

   mdio_phy_slave u_dut (
      .clk(clk), .rst_n(rst_n), .phy_addr(paddr), .link_up(link),
      .mdc(mdc), .mdio_i(bus), .mdio_o(dut_o), .mdio_oe(dut_oe)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input logic [4:0] ra);
      logic [15:0] a;
      logic [15:0] r;
      a = ref_regs[4];
      case (ra)
         5'd1:  r = link ? 16'h782C : 16'h0000;
         5'd5:  r = 16'h4001 | (a & 16'h01E0);
         5'd18: begin
            r = 16'h0000;
            if (link) begin
               r[11] = a[8] | a[6];
               r[10] = a[7] | a[8];
            end
         end
         default: r = ref_regs[ra];
      endcase
      return r;
   endfunction

   task automatic send_bit(input logic b, output logic smp);
      mst = b;
      repeat (HALF) @(negedge clk);
      smp = bus;
      mdc = 1'b1;
      repeat (HALF) @(negedge clk);
      mdc = 1'b0;
   endtask

   task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input int pre_len, input logic st2,
                        output logic [15:0] rd, output logic ta0, output logic seen);
      logic s;
      oe_seen = 1'b0;
      for (int i = 0; i < pre_len; i++) send_bit(1'b1, s);
      send_bit(1'b0, s);
      send_bit(st2, s);
      for (int i = 1; i >= 0; i--) send_bit(op[i], s);
      for (int i = 4; i >= 0; i--) send_bit(pa[i], s);
      for (int i = 4; i >= 0; i--) send_bit(ra[i], s);
      if (op == 2'b01) begin
         send_bit(1'b1, s);
         send_bit(1'b0, s);
      end else begin
         send_bit(1'b1, s);
         send_bit(1'b1, s);
      end
      ta0 = s;
      for (int i = 15; i >= 0; i--) begin
         send_bit((op == 2'b01) ? wd[i] : 1'b1, s);
         rd[i] = s;
      end
      mst = 1'b1;
      repeat (2*HALF) @(negedge clk);
      seen = oe_seen;
      if (op == 2'b01 && pa == paddr && pre_len >= 32 && st2) ref_regs[ra] = wd;
   endtask

   task automatic do_read(input logic [4:0] ra, input string req);
      logic [15:0] rd;
      logic ta0, seen;
      frame(2'b10, paddr, ra, 16'h0, 32, 1'b1, rd, ta0, seen);
      check(rd == exp_read(ra), req, rd, exp_read(ra));
   endtask

   task automatic do_write(input logic [4:0] ra, input logic [15:0] wd);
      logic [15:0] rd;
      logic ta0, seen;
      frame(2'b01, paddr, ra, wd, 32, 1'b1, rd, ta0, seen);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      logic ta0, seen;
      void'($urandom(32'h5EED1234));
      for (int i = 0; i < 32; i++) ref_regs[i] = 16'h0;
      ref_regs[0] = 16'h3100; ref_regs[2] = 16'h0300;
      ref_regs[3] = 16'hE400; ref_regs[4] = 16'h01E1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R6 reset state
      check(dut_oe == 1'b0, "R6 oe after reset", {15'd0, dut_oe}, 16'h0);
      do_read(5'd0, "R6 reg0 reset");
      do_read(5'd2, "R6 reg2 reset");
      do_read(5'd3, "R6 reg3 reset");
      do_read(5'd4, "R6 reg4 reset");
      do_read(5'd7, "R6 reg7 reset");

      // R2 R3 R10 read framing and output-enable
      frame(2'b10, paddr, 5'd0, 16'h0, 32, 1'b1, rd, ta0, seen);
      check(rd == 16'h3100, "R2 read MSB first", rd, 16'h3100);
      check(ta0 == 1'b0, "R3 turnaround zero", {15'd0, ta0}, 16'h0);
      check(seen == 1'b1, "R10 oe during read", {15'd0, seen}, 16'h1);
      check(dut_oe == 1'b0, "R10 oe released", {15'd0, dut_oe}, 16'h0);

      // R7 link view
      do_read(5'd1, "R7 status link up");
      link = 1'b0;
      do_read(5'd1, "R7 status link down");
      do_read(5'd18, "R9 diag link down");
      link = 1'b1;

      // R8 R9 with various advertisement values
      do_read(5'd5, "R8 lpa reset adv");
      do_read(5'd18, "R9 diag reset adv");
      do_write(5'd4, 16'h0020);
      do_read(5'd5, "R8 lpa 10half");
      do_read(5'd18, "R9 diag 10half");
      do_write(5'd4, 16'h0040);
      do_read(5'd18, "R9 diag 10full");
      do_write(5'd4, 16'h0080);
      do_read(5'd18, "R9 diag 100half");
      do_write(5'd4, 16'h0100);
      do_read(5'd18, "R9 diag 100full");
      do_read(5'd5, "R8 lpa 100full");

      // R4 storage write, write to computed register
      frame(2'b01, paddr, 5'd9, 16'hA5C3, 32, 1'b1, rd, ta0, seen);
      check(seen == 1'b0, "R10 no oe on write", {15'd0, seen}, 16'h0);
      do_read(5'd9, "R4 write readback");
      do_write(5'd1, 16'h0000);
      do_read(5'd1, "R7 status ignores write");

      // R1 short preamble
      frame(2'b01, paddr, 5'd9, 16'h0000, 31, 1'b1, rd, ta0, seen);
      do_read(5'd9, "R1 short preamble no write");
      // R12 bad start
      frame(2'b01, paddr, 5'd9, 16'h1111, 32, 1'b0, rd, ta0, seen);
      do_read(5'd9, "R12 bad start no write");
      // R11 unused opcodes
      frame(2'b11, paddr, 5'd9, 16'h2222, 32, 1'b1, rd, ta0, seen);
      check(seen == 1'b0, "R11 op11 no drive", {15'd0, seen}, 16'h0);
      frame(2'b00, paddr, 5'd9, 16'h3333, 32, 1'b1, rd, ta0, seen);
      check(seen == 1'b0, "R11 op00 no drive", {15'd0, seen}, 16'h0);
      do_read(5'd9, "R11 unused opcodes no write");

      // R5 foreign address
      frame(2'b10, paddr ^ 5'd4, 5'd0, 16'h0, 32, 1'b1, rd, ta0, seen);
      check(rd == 16'hFFFF, "R5 foreign read ones", rd, 16'hFFFF);
      check(seen == 1'b0, "R5 foreign no drive", {15'd0, seen}, 16'h0);
      frame(2'b01, paddr ^ 5'd4, 5'd9, 16'h4444, 32, 1'b1, rd, ta0, seen);
      do_read(5'd9, "R5 foreign write ignored");

      // random mix
      for (int it = 0; it < 60; it++) begin
         logic [1:0] op;
         logic [4:0] pa, ra;
         logic [15:0] wd;
         int sel;
         sel = int'($urandom % 8);
         op = (sel < 4) ? 2'b10 : 2'b01;
         if (it % 20 == 0) paddr = 5'($urandom);
         if (it % 7 == 3) link = ~link;
         pa = ($urandom % 6 == 0) ? (paddr ^ 5'd1) : paddr;
         ra = 5'($urandom);
         wd = 16'($urandom);
         frame(op, pa, ra, wd, 32, 1'b1, rd, ta0, seen);
         if (op == 2'b10) begin
            if (pa == paddr) begin
               check(rd == exp_read(ra), "R2 random read", rd, exp_read(ra));
               check(ta0 == 1'b0, "R3 random turnaround", {15'd0, ta0}, 16'h0);
            end else begin
               check(rd == 16'hFFFF && !seen, "R5 random foreign", rd, 16'hFFFF);
            end
         end else begin
            check(seen == 1'b0, "R4 random write no drive", {15'd0, seen}, 16'h0);
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule